// File: doc/BRIEF.md
# Frame Counter and Paired Interrupt Controller

This block gathers eight audio-interface events into a single interrupt line. Each event has an enable bit and a pending bit. The two bits sit next to each other in one 32-bit control register. When an event fires, its pending bit is set whether or not the event is enabled. The interrupt output goes high while any enabled event is pending.

Seven of the events arrive as single-cycle strobes from detection logic elsewhere in the chip. The eighth comes from inside the block. A 32-bit frame counter advances on every frame-sync strobe. When an increment lands the counter on a software-programmed match value, the frame event fires. Software reaches the block through a simple register port. Reads are combinational from the address, and a write takes effect on the clock edge while the write strobe is high.

Top module: `frame_irq_ctrl`

## Requirements
- R1: After reset, every enable and pending bit is 0, the frame counter and the match register read 0, and `irq` is 0.
- R2: The control register is at address 0x00. Pair k (k = 0..7) has its enable bit at position 17+2k and its pending bit at 16+2k. From pair 7 down to pair 0, the events are: frame match, message, new peak, clocks stopped, sync error, sync OK, new sample rate, status. Bits 15:0 read as 0, and writing them changes nothing.
- R3: The frame counter is at address 0x40 and can be read and written. Each `frame_sync` pulse adds 1 to it, and it wraps from 0xFFFFFFFF to 0. If a write to the counter lands on the same cycle as a pulse, the written value wins.
- R4: The match register is at address 0x50 and can be read and written. If a `frame_sync` increment makes the counter equal the match value, pending bit 7 is set on that same edge. A counter write never sets it.
- R5: A pulse on `event_strobe[k]` (k = 0..6) sets pending bit k on the next edge.
- R6: Writing 1 to a pending bit clears it, and writing 0 leaves it as it is. Each write stores the enable bits exactly as written.
- R7: If an event and a clearing write hit the same pending bit in the same cycle, the bit stays set.
- R8: `irq` is a register output. After every edge it equals the OR over all pairs of (enable AND pending), taken from the register state after that edge.
- R9: A pending bit is set even when its enable is 0; the enable only gates `irq`.
- R10: Reads from any other address return 0, and writes to any other address change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 8 | Register byte address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| frame_sync | input | 1 | One-cycle frame-sync strobe |
| event_strobe | input | 7 | One-cycle strobes for events 0..6 |
| irq | output | 1 | Combined interrupt line |

## Verification
The assertions assume that event and frame-sync inputs are single-cycle strobes. They also assume that a match-register write never coincides with a frame increment that the match check relies on. The bench keeps to this by driving each strobe for exactly one cycle, and it writes the match register only in cycles with no `frame_sync`. Every stimulus step is compared against a model of the register state kept in the bench. The model is built from the requirements alone. It covers every event index, every single-enable mask, counter wrap, and the case where a clear and an event collide.

// File: rtl/frirq_pkg.sv
package frirq_pkg;
    localparam int NUM_PAIRS  = 8;
    localparam int NUM_EXT    = NUM_PAIRS - 1;
    localparam int FRAME_PAIR = NUM_PAIRS - 1;
    localparam int CNT_W      = 32;

    typedef struct packed {
        logic [NUM_PAIRS-1:0] en;
        logic [NUM_PAIRS-1:0] pend;
        logic                 irq;
    } pair_state_t;

    typedef struct packed {
        logic [CNT_W-1:0] count;
        logic [CNT_W-1:0] match;
    } frame_state_t;
endpackage

// File: rtl/frirq_frame_counter.sv
module frirq_frame_counter #(
    parameter int W = frirq_pkg::CNT_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sync_i,
    input  logic         cnt_wr_i,
    input  logic         match_wr_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] count_o,
    output logic [W-1:0] match_o,
    output logic         hit_o
);
    typedef struct packed {
        logic [W-1:0] count;
        logic [W-1:0] match;
    } st_t;

    st_t st_d, st_q;
    logic [W-1:0] count_inc;

    always_comb begin
        st_d      = st_q;
        count_inc = st_q.count + W'(1);
        hit_o     = 1'b0;
        if (cnt_wr_i) begin
            st_d.count = wdata_i;
        end else if (sync_i) begin
            st_d.count = count_inc;
            hit_o      = (count_inc == st_q.match);
        end
        if (match_wr_i) st_d.match = wdata_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count_o = st_q.count;
    assign match_o = st_q.match;

    // R3
    inc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_i && !cnt_wr_i) |=> count_o == $past(count_o) + W'(1));
    // R3
    cnt_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr_i |=> count_o == $past(wdata_i));
    // R4
    hit_equal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_o && !match_wr_i) |=> count_o == match_o);
endmodule

// File: rtl/frirq_pair_bank.sv
module frirq_pair_bank #(
    parameter int N = frirq_pkg::NUM_PAIRS
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_i,
    input  logic [2*N-1:0] wfield_i,
    input  logic [N-1:0]   set_i,
    output logic [2*N-1:0] rfield_o,
    output logic           irq_o
);
    typedef struct packed {
        logic [N-1:0] en;
        logic [N-1:0] pend;
        logic         irq;
    } st_t;

    st_t st_d, st_q;
    logic [N-1:0] wen, wclr;

    for (genvar k = 0; k < N; k++) begin : g_unpack
        assign wen[k]            = wfield_i[2*k+1];
        assign wclr[k]           = wfield_i[2*k];
        assign rfield_o[2*k+1]   = st_q.en[k];
        assign rfield_o[2*k]     = st_q.pend[k];
    end

    always_comb begin
        st_d = st_q;
        if (wr_i) begin
            st_d.en   = wen;
            st_d.pend = st_q.pend & ~wclr;
        end
        st_d.pend = st_d.pend | set_i;
        st_d.irq  = |(st_d.en & st_d.pend);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq_o = st_q.irq;

    for (genvar k = 0; k < N; k++) begin : g_chk
        // R5 R7 R9
        pend_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
            set_i[k] |=> rfield_o[2*k]);
        // R6
        pend_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_i && wclr[k] && !set_i[k]) |=> !rfield_o[2*k]);
    end

    // R8
    irq_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == |(st_q.en & st_q.pend));
endmodule

// File: rtl/frame_irq_ctrl.sv
module frame_irq_ctrl #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter logic [ADDR_W-1:0] CTRL_ADDR  = 8'h00,
    parameter logic [ADDR_W-1:0] COUNT_ADDR = 8'h40,
    parameter logic [ADDR_W-1:0] MATCH_ADDR = 8'h50
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              frame_sync,
    input  logic [frirq_pkg::NUM_EXT-1:0] event_strobe,
    output logic              irq
);
    import frirq_pkg::*;
    localparam int FIELD_W = 2 * NUM_PAIRS;
    localparam int FIELD_LO = DATA_W - FIELD_W;

    logic sel_ctrl, sel_count, sel_match;
    logic [DATA_W-1:0] count_v, match_v;
    logic [FIELD_W-1:0] ctrl_field;
    logic frame_hit;
    logic [NUM_PAIRS-1:0] set_vec;

    assign sel_ctrl  = (reg_addr == CTRL_ADDR);
    assign sel_count = (reg_addr == COUNT_ADDR);
    assign sel_match = (reg_addr == MATCH_ADDR);
    assign set_vec   = {frame_hit, event_strobe};

    frirq_frame_counter #(.W(DATA_W)) u_frame (
        .clk        (clk),
        .rst_n      (rst_n),
        .sync_i     (frame_sync),
        .cnt_wr_i   (reg_wr && sel_count),
        .match_wr_i (reg_wr && sel_match),
        .wdata_i    (reg_wdata),
        .count_o    (count_v),
        .match_o    (match_v),
        .hit_o      (frame_hit)
    );

    frirq_pair_bank #(.N(NUM_PAIRS)) u_pairs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_i     (reg_wr && sel_ctrl),
        .wfield_i (reg_wdata[DATA_W-1:FIELD_LO]),
        .set_i    (set_vec),
        .rfield_o (ctrl_field),
        .irq_o    (irq)
    );

    always_comb begin
        reg_rdata = '0;
        if (sel_ctrl)       reg_rdata = {ctrl_field, {FIELD_LO{1'b0}}};
        else if (sel_count) reg_rdata = count_v;
        else if (sel_match) reg_rdata = match_v;
    end

    // R2
    low_half_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel_ctrl |-> reg_rdata[FIELD_LO-1:0] == '0);
    // R4
    frame_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_hit |=> reg_rdata[DATA_W-2] || !sel_ctrl);
endmodule

// File: tb/frame_irq_ctrl_test.sv
`timescale 1ns/1ps
module frame_irq_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        frame_sync = 1'b0;
    logic [6:0]  event_strobe = '0;
    logic        irq;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    logic [7:0]  m_en, m_pend;
    logic [31:0] m_count, m_match;

    always #2.5 clk = ~clk;

    frame_irq_ctrl uut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .frame_sync(frame_sync),
        .event_strobe(event_strobe), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] pack_ctrl(input logic [7:0] en, input logic [7:0] pd);
        logic [31:0] v = '0;
        for (int k = 0; k < 8; k++) begin
            v[17+2*k] = en[k];
            v[16+2*k] = pd[k];
        end
        return v;
    endfunction

    // one cycle of stimulus; the model is updated from the requirements
    task automatic step(input bit wr, input logic [7:0] a, input logic [31:0] d,
                        input bit sy, input logic [6:0] ev);
        logic [7:0] clr;
        logic [7:0] setv;
        bit hit;
        @(negedge clk);
        reg_wr = wr; reg_addr = a; reg_wdata = d; frame_sync = sy; event_strobe = ev;
        @(posedge clk);
        #1;
        reg_wr = 0; frame_sync = 0; event_strobe = '0;
        hit = 0;
        if (wr && a == 8'h40) m_count = d;
        else if (sy) begin
            m_count = m_count + 1;
            hit = (m_count == m_match);
        end
        if (wr && a == 8'h50) m_match = d;
        setv = {hit, ev};
        if (wr && a == 8'h00) begin
            for (int k = 0; k < 8; k++) begin
                clr[k] = d[16+2*k];
                m_en[k] = d[17+2*k];
            end
            m_pend = m_pend & ~clr;
        end
        m_pend = m_pend | setv;
    endtask

    task automatic check_all(input string req);
        reg_addr = 8'h00; #0.5;
        chk(req, reg_rdata, pack_ctrl(m_en, m_pend));
        reg_addr = 8'h40; #0.5;
        chk(req, reg_rdata, m_count);
        reg_addr = 8'h50; #0.5;
        chk(req, reg_rdata, m_match);
        chk(req, {31'd0, irq}, {31'd0, |(m_en & m_pend)});
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        m_en = '0; m_pend = '0; m_count = '0; m_match = '0;
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        check_all("R1");
        @(negedge clk); rst_n = 1'b1;

        // R5 R9: each event with enables off, then cleared (R6)
        for (int k = 0; k < 7; k++) begin
            step(0, 8'h00, 0, 0, 7'(1 << k));
            check_all("R5/R9");
            step(1, 8'h00, 32'h5555_0000, 0, 0);
            check_all("R6");
        end

        // R8: each single enable against each single pending event
        for (int e = 0; e < 7; e++) begin
            step(1, 8'h00, 32'h1 << (17 + 2*e), 0, 0);
            for (int k = 0; k < 7; k++) begin
                step(0, 8'h00, 0, 0, 7'(1 << k));
                check_all("R8");
                step(1, 8'h00, (32'h1 << (17 + 2*e)) | (32'h1 << (16 + 2*k)), 0, 0);
                check_all("R6 clear");
            end
        end

        // R6: writing 0 leaves pending
        step(0, 8'h00, 0, 0, 7'h7F);
        step(1, 8'h00, 32'hAAAA_0000, 0, 0);
        check_all("R6 write0");
        // R7: event and clear same cycle
        step(1, 8'h00, 32'hAAAA_0000 | (32'h1 << 20), 0, 7'b0000100);
        check_all("R7");
        step(1, 8'h00, 32'h5555_0000, 0, 0);
        check_all("R6 all");

        // R2: low half ignored, reads zero
        step(1, 8'h00, 32'h0000_FFFF, 0, 0);
        check_all("R2");

        // R10: unmapped reads zero, writes ignored
        step(1, 8'h10, 32'hFFFF_FFFF, 0, 0);
        step(1, 8'h44, 32'h1234_5678, 0, 0);
        reg_addr = 8'h10; #0.5; chk("R10", reg_rdata, 0);
        reg_addr = 8'h60; #0.5; chk("R10", reg_rdata, 0);
        check_all("R10");

        // R3: counting and wrap
        step(1, 8'h40, 32'hFFFF_FFFD, 0, 0);
        for (int i = 0; i < 5; i++) begin
            step(0, 8'h00, 0, 1, 0);
            check_all("R3 wrap");
        end
        // R3: write beats sync
        step(1, 8'h40, 32'd100, 1, 0);
        check_all("R3 write wins");

        // R4: match sweep with frame enable
        step(1, 8'h00, 32'h8000_0000, 0, 0);
        step(1, 8'h50, 32'd105, 0, 0);
        for (int i = 0; i < 8; i++) begin
            step(0, 8'h00, 0, 1, 0);
            check_all("R4 match");
        end
        // R4: writing the counter to the match value does not fire
        step(1, 8'h00, 32'hC000_0000, 0, 0);
        step(1, 8'h40, 32'd105, 0, 0);
        check_all("R4 no fire on write");
        // R4: match at wrap
        step(1, 8'h50, 32'd0, 0, 0);
        step(1, 8'h40, 32'hFFFF_FFFF, 0, 0);
        step(0, 8'h00, 0, 1, 0);
        check_all("R4 wrap match");

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule